// File: doc/BRIEF.md
# Loop Trip-Count Branch Predictor

This block predicts conditional branches whose direction follows a counted loop: a run of identical outcomes of fixed length, closed by one outcome in the other direction. It keeps a small direct-mapped table indexed by the low bits of the branch address. Each entry holds a partial tag, the dominant direction, a learned trip limit, a running count of dominant outcomes since the last exit, and a 2-bit confidence counter.

The fetch side presents an address on the lookup port and gets back a combinational prediction with a valid flag. The flag is set only for a tag hit whose confidence is saturated. The resolve side reports each retired conditional branch with its address and outcome, and the table trains on it at the clock edge. The block compares an 8-bit counter against a stored limit, so it predicts loops of any length up to 255 iterations exactly. No direction history of that length is needed.

Top module: `lp_loop_pred`

## Requirements
- R1: After the active-low asynchronous reset every entry is empty, and `pred_valid_o` and `pred_taken_o` read 0 for every lookup address.
- R2: The entry index is `pc[IDX_W-1:0]` and the tag is the XOR fold of `pc[PC_W-1:IDX_W]` into TAG_W bits. With the defaults the tag is `pc[9:4] ^ pc[15:10]`. A lookup whose entry is empty or holds a different tag gives `pred_valid_o = 0` and `pred_taken_o = 0`.
- R3: An update that misses overwrites the entry. The new entry takes the update's tag, the outcome as its dominant direction, count 1, limit 0 and confidence 0.
- R4: An update that hits with the dominant outcome raises the count by one.
- R5: An update that hits with the opposite outcome (an exit) sets the count to 0. If the count equalled the limit, confidence rises by one and saturates at 3. Otherwise the limit is reloaded with the count and confidence drops to 0.
- R6: `pred_valid_o` is 1 only for a tag hit whose confidence is 3.
- R7: When the prediction is valid, `pred_taken_o` is the opposite of the dominant direction if the count equals the limit, and the dominant direction otherwise.
- R8: A dominant-outcome hit while the count is 255 invalidates the entry.
- R9: A lookup and an update in the same cycle, to the same entry, see the table state from before that update.
- R10: A loop with a fixed trip count from 1 to 255, in either dominant direction, is predicted correctly on every occurrence once four exits have been seen since allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pc_i | input | PC_W | Address of the branch being predicted |
| pred_valid_o | output | 1 | Prediction is confident and may be used |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The directed cases target the exit iteration, because a design that compared the count against the limit off by one would predict the exit one occurrence early or late. A trained loop is then run once with a longer trip count. A design that kept confidence after a mismatch would go on predicting the stale exit point. The other directed cases are a 250-iteration loop and a run of more than 255 dominant outcomes. A count that wrapped instead of invalidating would resurrect a confident but wrong prediction. An aliasing address that shares an index but not a tag checks that the old entry is evicted and not matched. Random mixes of looping and noisy branches over a small aliasing address pool are compared step by step against a reference model. These cover not-taken-dominant loops and same-cycle lookup against update.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int unsigned CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_SAT = '1;

  function automatic logic [CONF_W-1:0] conf_bump(input logic [CONF_W-1:0] c);
    return (c == CONF_SAT) ? c : CONF_W'(c + 1'b1);
  endfunction
endpackage

// File: rtl/lp_pc_split.sv
module lp_pc_split #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 6
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  assign idx_o = pc_i[IDX_W-1:0];

  // fold every upper address bit into the partial tag
  always_comb begin
    tag_o = '0;
    for (int i = IDX_W; i < PC_W; i++) begin
      tag_o[(i - IDX_W) % TAG_W] = tag_o[(i - IDX_W) % TAG_W] ^ pc_i[i];
    end
  end
endmodule

// File: rtl/lp_predict.sv
module lp_predict #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned CNT_W = 8
) (
  input  logic                      ent_v_i,
  input  logic [TAG_W-1:0]          ent_tag_i,
  input  logic                      ent_dir_i,
  input  logic [CNT_W-1:0]          ent_lim_i,
  input  logic [CNT_W-1:0]          ent_cnt_i,
  input  logic [lp_pkg::CONF_W-1:0] ent_conf_i,
  input  logic [TAG_W-1:0]          lk_tag_i,
  output logic                      pred_valid_o,
  output logic                      pred_taken_o
);
  logic hit;
  logic at_exit;

  assign hit          = ent_v_i && (ent_tag_i == lk_tag_i);
  assign at_exit      = (ent_cnt_i == ent_lim_i);
  assign pred_valid_o = hit && (ent_conf_i == lp_pkg::CONF_SAT);
  assign pred_taken_o = pred_valid_o && (ent_dir_i ^ at_exit);
endmodule

// File: rtl/lp_train.sv
module lp_train #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned CNT_W = 8
) (
  input  logic                      cur_v_i,
  input  logic [TAG_W-1:0]          cur_tag_i,
  input  logic                      cur_dir_i,
  input  logic [CNT_W-1:0]          cur_lim_i,
  input  logic [CNT_W-1:0]          cur_cnt_i,
  input  logic [lp_pkg::CONF_W-1:0] cur_conf_i,
  input  logic [TAG_W-1:0]          upd_tag_i,
  input  logic                      upd_taken_i,
  output logic                      hit_o,
  output logic                      dom_o,
  output logic                      nxt_v_o,
  output logic [TAG_W-1:0]          nxt_tag_o,
  output logic                      nxt_dir_o,
  output logic [CNT_W-1:0]          nxt_lim_o,
  output logic [CNT_W-1:0]          nxt_cnt_o,
  output logic [lp_pkg::CONF_W-1:0] nxt_conf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign hit_o = cur_v_i && (cur_tag_i == upd_tag_i);
  assign dom_o = (upd_taken_i == cur_dir_i);

  always_comb begin
    nxt_v_o    = cur_v_i;
    nxt_tag_o  = cur_tag_i;
    nxt_dir_o  = cur_dir_i;
    nxt_lim_o  = cur_lim_i;
    nxt_cnt_o  = cur_cnt_i;
    nxt_conf_o = cur_conf_i;
    if (!hit_o) begin
      nxt_v_o    = 1'b1;
      nxt_tag_o  = upd_tag_i;
      nxt_dir_o  = upd_taken_i;
      nxt_lim_o  = '0;
      nxt_cnt_o  = CNT_W'(1);
      nxt_conf_o = '0;
    end else if (dom_o) begin
      if (cur_cnt_i == CNT_MAX) nxt_v_o = 1'b0;  // trip too long to track
      else nxt_cnt_o = CNT_W'(cur_cnt_i + 1'b1);
    end else begin
      if (cur_cnt_i == cur_lim_i) begin
        nxt_conf_o = lp_pkg::conf_bump(cur_conf_i);
      end else begin
        nxt_lim_o  = cur_cnt_i;
        nxt_conf_o = '0;
      end
      nxt_cnt_o = '0;
    end
  end
endmodule

// File: rtl/lp_loop_pred.sv
module lp_loop_pred #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned CNT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            pred_valid_o,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned CW      = lp_pkg::CONF_W;

  logic             ent_v    [ENTRIES];
  logic [TAG_W-1:0] ent_tag  [ENTRIES];
  logic             ent_dir  [ENTRIES];
  logic [CNT_W-1:0] ent_lim  [ENTRIES];
  logic [CNT_W-1:0] ent_cnt  [ENTRIES];
  logic [CW-1:0]    ent_conf [ENTRIES];

  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, upd_tag;

  lp_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_lk_split (
    .pc_i(lk_pc_i), .idx_o(lk_idx), .tag_o(lk_tag)
  );
  lp_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_upd_split (
    .pc_i(upd_pc_i), .idx_o(upd_idx), .tag_o(upd_tag)
  );

  lp_predict #(.TAG_W(TAG_W), .CNT_W(CNT_W)) i_predict (
    .ent_v_i     (ent_v[lk_idx]),
    .ent_tag_i   (ent_tag[lk_idx]),
    .ent_dir_i   (ent_dir[lk_idx]),
    .ent_lim_i   (ent_lim[lk_idx]),
    .ent_cnt_i   (ent_cnt[lk_idx]),
    .ent_conf_i  (ent_conf[lk_idx]),
    .lk_tag_i    (lk_tag),
    .pred_valid_o(pred_valid_o),
    .pred_taken_o(pred_taken_o)
  );

  logic             cur_v, cur_dir;
  logic [TAG_W-1:0] cur_tag;
  logic [CNT_W-1:0] cur_lim, cur_cnt;
  logic [CW-1:0]    cur_conf;
  logic             upd_hit, upd_dom;
  logic             nxt_v, nxt_dir;
  logic [TAG_W-1:0] nxt_tag;
  logic [CNT_W-1:0] nxt_lim, nxt_cnt;
  logic [CW-1:0]    nxt_conf;

  assign cur_v    = ent_v[upd_idx];
  assign cur_tag  = ent_tag[upd_idx];
  assign cur_dir  = ent_dir[upd_idx];
  assign cur_lim  = ent_lim[upd_idx];
  assign cur_cnt  = ent_cnt[upd_idx];
  assign cur_conf = ent_conf[upd_idx];

  lp_train #(.TAG_W(TAG_W), .CNT_W(CNT_W)) i_train (
    .cur_v_i    (cur_v),
    .cur_tag_i  (cur_tag),
    .cur_dir_i  (cur_dir),
    .cur_lim_i  (cur_lim),
    .cur_cnt_i  (cur_cnt),
    .cur_conf_i (cur_conf),
    .upd_tag_i  (upd_tag),
    .upd_taken_i(upd_taken_i),
    .hit_o      (upd_hit),
    .dom_o      (upd_dom),
    .nxt_v_o    (nxt_v),
    .nxt_tag_o  (nxt_tag),
    .nxt_dir_o  (nxt_dir),
    .nxt_lim_o  (nxt_lim),
    .nxt_cnt_o  (nxt_cnt),
    .nxt_conf_o (nxt_conf)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic wr;
    assign wr = upd_valid_i && (upd_idx == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_v[e]    <= 1'b0;
        ent_tag[e]  <= '0;
        ent_dir[e]  <= 1'b0;
        ent_lim[e]  <= '0;
        ent_cnt[e]  <= '0;
        ent_conf[e] <= '0;
      end else if (wr) begin
        ent_v[e]    <= nxt_v;
        ent_tag[e]  <= nxt_tag;
        ent_dir[e]  <= nxt_dir;
        ent_lim[e]  <= nxt_lim;
        ent_cnt[e]  <= nxt_cnt;
        ent_conf[e] <= nxt_conf;
      end
    end
  end
endmodule

// File: rtl/lp_loop_pred_chk.sv
module lp_loop_pred_chk #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      upd_valid_i,
  input logic                      pred_valid_o,
  input logic [IDX_W-1:0]          lk_idx,
  input logic [IDX_W-1:0]          upd_idx,
  input logic                      upd_hit,
  input logic                      upd_dom,
  input logic [CNT_W-1:0]          cur_cnt,
  input logic [CNT_W-1:0]          cur_lim,
  input logic                      ent_v    [1 << IDX_W],
  input logic [CNT_W-1:0]          ent_lim  [1 << IDX_W],
  input logic [CNT_W-1:0]          ent_cnt  [1 << IDX_W],
  input logic [lp_pkg::CONF_W-1:0] ent_conf [1 << IDX_W]
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R3
  alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_hit |=>
      ent_v[$past(upd_idx)] && ent_cnt[$past(upd_idx)] == CNT_W'(1) &&
      ent_conf[$past(upd_idx)] == '0);

  // R4
  dom_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_hit && upd_dom && cur_cnt != CNT_MAX |=>
      ent_cnt[$past(upd_idx)] == CNT_W'($past(cur_cnt) + 1'b1));

  // R5
  exit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_hit && !upd_dom |=> ent_cnt[$past(upd_idx)] == '0);

  // R5
  relearn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_hit && !upd_dom && cur_cnt != cur_lim |=>
      ent_conf[$past(upd_idx)] == '0 && ent_lim[$past(upd_idx)] == $past(cur_cnt));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_hit && upd_dom && cur_cnt == CNT_MAX |=> !ent_v[$past(upd_idx)]);

  // R6
  conf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> ent_v[lk_idx] && ent_conf[lk_idx] == lp_pkg::CONF_SAT);
endmodule

bind lp_loop_pred lp_loop_pred_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_valid_i (upd_valid_i),
  .pred_valid_o(pred_valid_o),
  .lk_idx      (lk_idx),
  .upd_idx     (upd_idx),
  .upd_hit     (upd_hit),
  .upd_dom     (upd_dom),
  .cur_cnt     (cur_cnt),
  .cur_lim     (cur_lim),
  .ent_v       (ent_v),
  .ent_lim     (ent_lim),
  .ent_cnt     (ent_cnt),
  .ent_conf    (ent_conf)
);

// File: tb/test_lp_loop_pred.sv
module test_lp_loop_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lk_pc = '0;
  logic        pred_valid, pred_taken;
  logic        upd_valid = 1'b0;
  logic [15:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic act_v, act_t;

  // reference model
  logic       m_v    [16];
  logic [5:0] m_tag  [16];
  logic       m_dir  [16];
  int         m_lim  [16];
  int         m_cnt  [16];
  int         m_conf [16];

  always #4 clk = ~clk;

  lp_loop_pred i_lp_loop_pred (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc),
    .pred_valid_o(pred_valid), .pred_taken_o(pred_taken),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken)
  );

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  function automatic logic [5:0] tag_of(logic [15:0] pc);
    return pc[9:4] ^ pc[15:10];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic m_update(input logic [15:0] pc, input logic t);
    int i = int'(pc[3:0]);
    if (!m_v[i] || m_tag[i] != tag_of(pc)) begin
      m_v[i] = 1'b1; m_tag[i] = tag_of(pc); m_dir[i] = t;
      m_cnt[i] = 1; m_lim[i] = 0; m_conf[i] = 0;
    end else if (t == m_dir[i]) begin
      if (m_cnt[i] == 255) m_v[i] = 1'b0;
      else m_cnt[i]++;
    end else begin
      if (m_cnt[i] == m_lim[i]) begin
        if (m_conf[i] < 3) m_conf[i]++;
      end else begin
        m_lim[i] = m_cnt[i];
        m_conf[i] = 0;
      end
      m_cnt[i] = 0;
    end
  endtask

  // drive, compare against the model's pre-edge state, then advance the model
  task automatic step(input logic [15:0] lk, input logic uv, input logic [15:0] up,
                      input logic ut);
    int i;
    logic hit, ev, et;
    @(negedge clk);
    lk_pc = lk; upd_valid = uv; upd_pc = up; upd_taken = ut;
    #1;
    act_v = pred_valid; act_t = pred_taken;
    i = int'(lk[3:0]);
    hit = m_v[i] && m_tag[i] == tag_of(lk);
    ev = hit && m_conf[i] == 3;
    et = ev && (m_dir[i] ^ (m_cnt[i] == m_lim[i]));
    if (uv && up[3:0] == lk[3:0])
      chk(act_v == ev, hit ? "R9 R6 valid" : "R9 R2 valid", int'(act_v), int'(ev));
    else
      chk(act_v == ev, hit ? "R6 valid" : "R2 valid", int'(act_v), int'(ev));
    chk(act_t == et, "R7 direction", int'(act_t), int'(et));
    if (uv) m_update(up, ut);
  endtask

  task automatic run_loop(input logic [15:0] pc, input logic dir, input int trip,
                          input logic exact, input string req);
    for (int k = 0; k < trip; k++) begin
      step(pc, 1'b1, pc, dir);
      if (exact) chk(act_v && act_t == dir, {req, " R4 body"}, int'(act_t), int'(dir));
    end
    step(pc, 1'b1, pc, ~dir);
    if (exact) chk(act_v && act_t == ~dir, {req, " R5 exit"}, int'(act_t), int'(~dir));
  endtask

  localparam logic [15:0] PC_A = 16'h0123;
  localparam logic [15:0] PC_B = 16'h0453;  // same index as PC_A, other tag
  localparam logic [15:0] PC_C = 16'h1A57;
  localparam logic [15:0] PC_D = 16'h2C69;
  localparam logic [15:0] PC_E = 16'h3B8E;

  logic [15:0] pool [8];

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_dir[i] = 1'b0;
      m_lim[i] = 0; m_cnt[i] = 0; m_conf[i] = 0;
    end
    pool[0] = PC_A; pool[1] = PC_B; pool[2] = PC_C; pool[3] = PC_D;
    pool[4] = 16'h7F13; pool[5] = 16'h4443; pool[6] = 16'h0007; pool[7] = 16'hFFF3;

    // R1: reset state
    #3;
    chk(pred_valid == 1'b0 && pred_taken == 1'b0, "R1 in reset", int'(pred_valid), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      step(16'(i) | 16'h0550, 1'b0, '0, 1'b0);
      chk(act_v == 1'b0 && act_t == 1'b0, "R1 empty after reset", int'(act_v), 0);
    end

    // R6: taken loop of trip 7 needs four exits before it is trusted
    for (int r = 0; r < 4; r++) begin
      run_loop(PC_A, 1'b1, 7, 1'b0, "R6");
      chk(r == 3 || act_v == 1'b0, "R6 untrained", int'(act_v), 0);
    end
    run_loop(PC_A, 1'b1, 7, 1'b1, "R10 trip7");
    run_loop(PC_A, 1'b1, 7, 1'b1, "R9 R10 trip7");

    // R5: longer trip clears confidence and relearns the limit
    run_loop(PC_A, 1'b1, 9, 1'b0, "R5");
    step(PC_A, 1'b0, '0, 1'b0);
    chk(act_v == 1'b0, "R5 confidence cleared", int'(act_v), 0);
    for (int r = 0; r < 3; r++) run_loop(PC_A, 1'b1, 9, 1'b0, "R5");
    run_loop(PC_A, 1'b1, 9, 1'b1, "R5 relearned");

    // R7: not-taken dominant loop
    for (int r = 0; r < 4; r++) run_loop(PC_C, 1'b0, 3, 1'b0, "R7");
    run_loop(PC_C, 1'b0, 3, 1'b1, "R7 not-taken loop");

    // R3: aliasing branch evicts the trained entry
    step(PC_A, 1'b0, '0, 1'b0);
    chk(act_v == 1'b1, "R3 trained before alias", int'(act_v), 1);
    step(PC_B, 1'b1, PC_B, 1'b1);
    step(PC_A, 1'b0, '0, 1'b0);
    chk(act_v == 1'b0, "R3 evicted by alias", int'(act_v), 0);

    // R10: trip count far beyond any history length
    for (int r = 0; r < 4; r++) run_loop(PC_D, 1'b1, 250, 1'b0, "R10");
    run_loop(PC_D, 1'b1, 250, 1'b1, "R10 trip250");

    // R8: more than 255 dominant outcomes invalidates
    for (int r = 0; r < 4; r++) run_loop(PC_E, 1'b1, 4, 1'b0, "R8");
    run_loop(PC_E, 1'b1, 4, 1'b1, "R8 trained");
    for (int k = 0; k < 256; k++) step(PC_E, 1'b1, PC_E, 1'b1);
    step(PC_E, 1'b0, '0, 1'b0);
    chk(act_v == 1'b0, "R8 invalidated", int'(act_v), 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [15:0] p;
      p = pool[$urandom % 8];
      if ($urandom % 2) begin
        int trip, runs;
        logic d;
        trip = 1 + int'($urandom % 12);
        runs = 1 + int'($urandom % 5);
        d = 1'($urandom % 2);
        for (int r = 0; r < runs; r++) run_loop(p, d, trip, 1'b0, "R10 random");
      end else begin
        for (int k = 0; k < 5; k++)
          step(pool[$urandom % 8], 1'($urandom % 4 != 0), p, 1'($urandom % 2));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule